// File: doc/BRIEF.md
# Cyclic Ring-Buffer DMA Channel

This block is a single DMA channel that moves 32-bit words between a ring buffer in memory and a streaming peripheral, in either direction. The ring is split into up to eight periods of equal length. The channel walks through them word by word and returns to the base address after the last period. It keeps looping until software stops it, or it halts by itself after one pass when cyclic mode is off. Each finished period sets an interrupt flag and advances a wrapping progress counter.

Software drives the channel through a 32-bit register port. It sets the direction, addresses, period length, period count and burst size, then writes the command register. Data moves in bursts. A pause or stop request is honoured only at a burst boundary, and the status register reports when the channel has actually paused or halted. A request line from the peripheral can gate the start of each burst. The memory side is a word-wide valid/ready master. On a read, the data is taken in the cycle of the handshake.

Top module: `cyc_ring_dma`

## Requirements
- R1: Writing a value with bit 0 set to the command register (0x00) while the channel is halted starts it. STATUS (0x0C) bit 0 then reads 1 while the channel is active.
- R2: CTRL (0x24) bits 15:12 select the direction. Value 4 reads memory from the source base (0x34) and sends the words to the peripheral. Value 2 takes words from the peripheral and writes them at the target base (0x3C). With any other value a start is ignored and STATUS bit 0 stays 0.
- R3: The period length in words is TC (0x44) bits 29:2. The period count is CONFIG bits 30:28 plus one for the memory-to-peripheral direction, and CONFIG bits 26:24 plus one for the other direction. Addresses rise by 4 from the base, stay word aligned, and return to the base after the last word of the last period.
- R4: With CTRL bits 9:8 equal to 2 the channel loops without end. With any other value it halts by itself after the last period, and STATUS bit 0 clears.
- R5: CONFIG bits 23:20 hold the burst length minus one (1 to 16 words). A burst never crosses a period end. Pause and stop act only between bursts.
- R6: CTRL bit 0 set requests a pause. Once the channel is paused, STATUS bit 1 reads 1 and there is no memory or peripheral traffic. Clearing the bit resumes at the next word.
- R7: Writing 0 to the command register halts the channel at the next burst boundary and clears STATUS bit 0. The next start begins again at period 0 and the base address.
- R8: With CTRL bit 1 set, a burst begins only while the peripheral request line is high. With the bit clear, the line is ignored.
- R9: INT_STATUS (0x10) bit 0 is set when each period completes. Writing 1 to INT_CLEAR (0x1C) bit 0 clears it. If a completion and a clear fall in the same cycle, the flag stays set.
- R10: The interrupt output equals INT_STATUS bit 0 AND command register bit 0.
- R11: The low PROG_W bits (16 by default) of the progress register (0x54) count completed periods. A start clears them, and they wrap from all ones to 0.
- R12: After reset, every register reads 0, the interrupt output is 0 and there is no bus traffic.
- R13: A memory request keeps its address and data stable until it is accepted, and a peripheral word keeps its data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, valid in the cycle of acceptance |
| per_req | input | 1 | Peripheral flow-control request |
| per_tx_valid | output | 1 | Word to peripheral valid |
| per_tx_data | output | 32 | Word to peripheral |
| per_tx_ready | input | 1 | Peripheral accepts the word |
| per_rx_valid | input | 1 | Word from peripheral valid |
| per_rx_data | input | 32 | Word from peripheral |
| per_rx_ready | output | 1 | Channel accepts the peripheral word |
| irq | output | 1 | Period-complete interrupt |

## Verification
A register write takes effect at the next clock edge, and its read-back or STATUS change is visible in the cycle after the write strobe. For that reason the bench reads registers only after a write has completed, and it samples combinational read data a short time after it sets the address. Pause and stop are not due after a fixed number of cycles, because the channel waits for the end of the current burst. The bench therefore polls STATUS until the confirming bit appears and only then compares word counts, sequences and the progress value. Handshakes are recorded once the inputs have settled in each cycle, so every stored word belongs to the edge that accepts it.

// File: rtl/dma_pkg.sv
// Shared constants and types for the cyclic ring DMA channel.
// Assumes byte register offsets on an 8-bit register address.
package dma_pkg;
    localparam logic [7:0] OFS_CMD    = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_INTST  = 8'h10;
    localparam logic [7:0] OFS_INTCLR = 8'h1C;
    localparam logic [7:0] OFS_CTRL   = 8'h24;
    localparam logic [7:0] OFS_CONFIG = 8'h28;
    localparam logic [7:0] OFS_SRC    = 8'h34;
    localparam logic [7:0] OFS_TRG    = 8'h3C;
    localparam logic [7:0] OFS_TC     = 8'h44;
    localparam logic [7:0] OFS_PROG   = 8'h54;

    localparam logic [3:0] DIR_TO_PER = 4'd4;
    localparam logic [3:0] DIR_TO_MEM = 4'd2;
    localparam logic [1:0] MODE_LOOP  = 2'd2;

    typedef enum logic [1:0] {ENG_IDLE, ENG_GAP, ENG_FETCH, ENG_PUT} eng_state_t;
endpackage

// File: rtl/dma_regs.sv
// Register bank: holds command, control, configuration, addresses, period
// length, interrupt flag and progress counter. Issues a start pulse to the
// engine. Assumes single-cycle writes and combinational reads.
module dma_regs
    import dma_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int PROG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_busy,
    input  logic              eng_paused,
    input  logic              period_done,
    output logic              start,
    output logic              run_en,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       cfg_q,
    output logic [31:0]       src_q,
    output logic [31:0]       trg_q,
    output logic [31:0]       tc_q,
    output logic              int_pend,
    output logic [PROG_W-1:0] prog_q,
    output logic              irq
);
    logic [7:0] a8;
    assign a8    = 8'(reg_addr);
    assign start = reg_wr && (a8 == OFS_CMD) && reg_wdata[0] && !eng_busy;
    assign irq   = int_pend && run_en;

    // Software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            ctrl_q <= '0;
            cfg_q  <= '0;
            src_q  <= '0;
            trg_q  <= '0;
            tc_q   <= '0;
        end else if (reg_wr) begin
            case (a8)
                OFS_CMD:    run_en <= reg_wdata[0];
                OFS_CTRL:   ctrl_q <= reg_wdata;
                OFS_CONFIG: cfg_q  <= reg_wdata;
                OFS_SRC:    src_q  <= {reg_wdata[31:2], 2'b00};
                OFS_TRG:    trg_q  <= {reg_wdata[31:2], 2'b00};
                OFS_TC:     tc_q   <= reg_wdata & 32'h3FFF_FFFC;
                default:    ;
            endcase
        end
    end

    // Period-complete flag: a completion takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_pend <= 1'b0;
        else if (period_done)
            int_pend <= 1'b1;
        else if (reg_wr && a8 == OFS_INTCLR && reg_wdata[0])
            int_pend <= 1'b0;
    end

    // Wrapping count of completed periods, cleared by each start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_q <= '0;
        else if (start)
            prog_q <= '0;
        else if (period_done)
            prog_q <= prog_q + 1'b1;
    end

    // Read multiplexer.
    always_comb begin
        case (a8)
            OFS_CMD:    reg_rdata = {31'd0, run_en};
            OFS_STATUS: reg_rdata = {30'd0, eng_paused, eng_busy};
            OFS_INTST:  reg_rdata = {31'd0, int_pend};
            OFS_CTRL:   reg_rdata = ctrl_q;
            OFS_CONFIG: reg_rdata = cfg_q;
            OFS_SRC:    reg_rdata = src_q;
            OFS_TRG:    reg_rdata = trg_q;
            OFS_TC:     reg_rdata = tc_q;
            OFS_PROG:   reg_rdata = 32'(prog_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_engine.sv
// Transfer engine: moves one word per fetch/put pair, groups words into
// bursts, walks the periods of the ring and wraps to the base. Pause, stop
// and flow control are sampled only in the gap between bursts. Assumes the
// configuration is stable while the channel is active; it is latched at start.
module dma_engine
    import dma_pkg::*;
#(
    parameter int CNT_W   = 28,
    parameter int BURST_W = 4,
    parameter int NPER_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run_en,
    input  logic               pause_req,
    input  logic               flow_en,
    input  logic               per_req,
    input  logic [3:0]         dir_code,
    input  logic               cyclic,
    input  logic [NPER_W-1:0]  nper_src,
    input  logic [NPER_W-1:0]  nper_trg,
    input  logic [BURST_W-1:0] burst_m1,
    input  logic [CNT_W-1:0]   period_words,
    input  logic [31:0]        src_base,
    input  logic [31:0]        trg_base,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ready,
    input  logic [31:0]        mem_rdata,
    output logic               tx_valid,
    output logic [31:0]        tx_data,
    input  logic               tx_ready,
    input  logic               rx_valid,
    input  logic [31:0]        rx_data,
    output logic               rx_ready,
    output logic               busy,
    output logic               paused,
    output logic               period_done
);
    eng_state_t         st_q;
    logic               to_per_q, cyc_q;
    logic [NPER_W-1:0]  nper_q, per_q;
    logic [BURST_W-1:0] burst_q, beat_q;
    logic [CNT_W-1:0]   pwords_q, word_q;
    logic [31:0]        base_q, addr_q, hold_q;
    logic               dir_ok, to_per_new, fetch_done, put_done;
    logic               last_word, last_beat, last_per;

    // Handshake and position decode.
    always_comb begin
        to_per_new  = (dir_code == DIR_TO_PER);
        dir_ok      = to_per_new || (dir_code == DIR_TO_MEM);
        fetch_done  = (st_q == ENG_FETCH) && (to_per_q ? mem_ready : rx_valid);
        put_done    = (st_q == ENG_PUT) && (to_per_q ? tx_ready : mem_ready);
        last_word   = (word_q == pwords_q - 1'b1);
        last_beat   = (beat_q == burst_q);
        last_per    = (per_q == nper_q);
        period_done = put_done && last_word;
    end

    // Sequencer: start, burst gap, fetch and put of each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ENG_IDLE;
            to_per_q <= 1'b0;
            cyc_q    <= 1'b0;
            nper_q   <= '0;
            per_q    <= '0;
            burst_q  <= '0;
            beat_q   <= '0;
            pwords_q <= '0;
            word_q   <= '0;
            base_q   <= '0;
            addr_q   <= '0;
            hold_q   <= '0;
        end else begin
            case (st_q)
                ENG_IDLE: if (start && dir_ok && period_words != '0) begin
                    to_per_q <= to_per_new;
                    cyc_q    <= cyclic;
                    nper_q   <= to_per_new ? nper_src : nper_trg;
                    burst_q  <= burst_m1;
                    pwords_q <= period_words;
                    base_q   <= to_per_new ? src_base : trg_base;
                    addr_q   <= to_per_new ? src_base : trg_base;
                    word_q   <= '0;
                    per_q    <= '0;
                    st_q     <= ENG_GAP;
                end
                ENG_GAP: if (!run_en) begin
                    word_q <= '0;
                    per_q  <= '0;
                    addr_q <= '0;
                    st_q   <= ENG_IDLE;
                end else if (!pause_req && (!flow_en || per_req)) begin
                    beat_q <= '0;
                    st_q   <= ENG_FETCH;
                end
                ENG_FETCH: if (fetch_done) begin
                    hold_q <= to_per_q ? mem_rdata : rx_data;
                    st_q   <= ENG_PUT;
                end
                ENG_PUT: if (put_done) begin
                    addr_q <= addr_q + 32'd4;
                    word_q <= word_q + 1'b1;
                    beat_q <= beat_q + 1'b1;
                    st_q   <= ENG_FETCH;
                    if (last_word) begin
                        word_q <= '0;
                        st_q   <= ENG_GAP;
                        if (last_per) begin
                            per_q  <= '0;
                            addr_q <= base_q;
                            if (!cyc_q) st_q <= ENG_IDLE;
                        end else begin
                            per_q <= per_q + 1'b1;
                        end
                    end else if (last_beat) begin
                        st_q <= ENG_GAP;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // Bus outputs follow the state.
    always_comb begin
        mem_valid = ((st_q == ENG_FETCH) && to_per_q) || ((st_q == ENG_PUT) && !to_per_q);
        mem_write = !to_per_q;
        mem_addr  = addr_q;
        mem_wdata = hold_q;
        tx_valid  = (st_q == ENG_PUT) && to_per_q;
        tx_data   = hold_q;
        rx_ready  = (st_q == ENG_FETCH) && !to_per_q;
        busy      = (st_q != ENG_IDLE);
        paused    = (st_q == ENG_GAP) && pause_req && run_en;
    end
endmodule

// File: rtl/cyc_ring_dma.sv
// Top of the cyclic ring DMA channel: joins the register bank and the
// transfer engine and decodes the control and configuration fields.
module cyc_ring_dma #(
    parameter int REG_AW    = 8,
    parameter int PROG_W    = 16,
    parameter int CNT_W     = 28,
    parameter int BURST_MAX = 16,
    parameter int NPER_MAX  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              per_req,
    output logic              per_tx_valid,
    output logic [31:0]       per_tx_data,
    input  logic              per_tx_ready,
    input  logic              per_rx_valid,
    input  logic [31:0]       per_rx_data,
    output logic              per_rx_ready,
    output logic              irq
);
    localparam int BURST_W = $clog2(BURST_MAX);
    localparam int NPER_W  = $clog2(NPER_MAX);

    logic              start, run_en, eng_busy, eng_paused, period_done, int_pend;
    logic [31:0]       ctrl_q, cfg_q, src_q, trg_q, tc_q;
    logic [PROG_W-1:0] prog_q;

    dma_regs #(.REG_AW(REG_AW), .PROG_W(PROG_W)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .eng_busy, .eng_paused, .period_done, .start, .run_en,
        .ctrl_q, .cfg_q, .src_q, .trg_q, .tc_q, .int_pend, .prog_q, .irq
    );

    dma_engine #(.CNT_W(CNT_W), .BURST_W(BURST_W), .NPER_W(NPER_W)) u_eng (
        .clk, .rst_n, .start, .run_en,
        .pause_req   (ctrl_q[0]),
        .flow_en     (ctrl_q[1]),
        .per_req,
        .dir_code    (ctrl_q[15:12]),
        .cyclic      (ctrl_q[9:8] == dma_pkg::MODE_LOOP),
        .nper_src    (cfg_q[28 +: NPER_W]),
        .nper_trg    (cfg_q[24 +: NPER_W]),
        .burst_m1    (cfg_q[20 +: BURST_W]),
        .period_words(tc_q[2 +: CNT_W]),
        .src_base    (src_q),
        .trg_base    (trg_q),
        .mem_valid, .mem_write, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata,
        .tx_valid    (per_tx_valid),
        .tx_data     (per_tx_data),
        .tx_ready    (per_tx_ready),
        .rx_valid    (per_rx_valid),
        .rx_data     (per_rx_data),
        .rx_ready    (per_rx_ready),
        .busy        (eng_busy),
        .paused      (eng_paused),
        .period_done
    );
endmodule

// File: rtl/dma_chk.sv
// Property checker for the cyclic ring DMA channel, bound to the top.
module dma_chk #(
    parameter int PROG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [31:0]       mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              per_tx_valid,
    input logic              per_tx_ready,
    input logic [31:0]       per_tx_data,
    input logic              per_rx_ready,
    input logic              eng_busy,
    input logic              eng_paused,
    input logic              int_pend,
    input logic [PROG_W-1:0] prog_q
);
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00); // R3
    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_paused |-> !mem_valid && !per_tx_valid && !per_rx_ready); // R6
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mem_valid && !per_tx_valid && !per_rx_ready); // R7
    AST_PERIOD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_q != $past(prog_q)) && (prog_q != '0) |-> int_pend); // R9
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata)); // R13
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        per_tx_valid && !per_tx_ready |=> per_tx_valid && $stable(per_tx_data)); // R13
endmodule

bind cyc_ring_dma dma_chk #(.PROG_W(PROG_W)) u_chk (
    .clk, .rst_n, .mem_valid, .mem_ready, .mem_addr, .mem_wdata,
    .per_tx_valid, .per_tx_ready, .per_tx_data, .per_rx_ready,
    .eng_busy, .eng_paused, .int_pend, .prog_q
);

// File: tb/sim_cyc_ring_dma.sv
// Self-checking bench: directed corners plus seeded random ring shapes.
module sim_cyc_ring_dma;
    localparam int PW = 8;
    localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h0C, A_INT = 8'h10, A_CLR = 8'h1C;
    localparam logic [7:0] A_CTRL = 8'h24, A_CFG = 8'h28, A_SRC = 8'h34, A_TRG = 8'h3C;
    localparam logic [7:0] A_TC = 8'h44, A_PROG = 8'h54;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_valid, mem_write, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic per_req = 1'b1, per_tx_valid, per_tx_ready = 1'b0;
    logic [31:0] per_tx_data;
    logic per_rx_valid = 1'b0, per_rx_ready, irq;
    logic [31:0] per_rx_data;

    logic [31:0] mem [0:1023];
    logic [31:0] sink [0:1023];
    int sink_cnt = 0, src_cnt = 0, n_chk = 0, n_bad = 0, cyc = 0;
    bit rx_pend = 0, rnd_rdy = 1, done = 0;

    always #4 clk = ~clk;

    cyc_ring_dma #(.PROG_W(PW)) u0 (.*);

    assign mem_rdata   = mem[mem_addr[11:2]];
    assign per_rx_data = 32'h0000_A000 + src_cnt;

    function automatic logic [31:0] mem_init(input int i);
        return 32'h5A00_0000 + i * 32'h0001_0003;
    endfunction

    // Bus models: drive ready/valid at negedge, record handshakes once settled.
    always @(negedge clk) begin
        if (rx_pend) src_cnt++;
        mem_ready    = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
        per_tx_ready = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
        per_rx_valid = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
        #1;
        rx_pend = per_rx_valid && per_rx_ready;
        if (mem_valid && mem_ready && mem_write) mem[mem_addr[11:2]] = mem_wdata;
        if (per_tx_valid && per_tx_ready) begin
            if (sink_cnt < 1024) sink[sink_cnt] = per_tx_data;
            sink_cnt++;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run exceeded limit, act=%0d exp<150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #2; d = reg_rdata;
    endtask

    task automatic wait_stat(input int bitn, input logic want, output bit ok);
        logic [31:0] d;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(A_STAT, d);
            if (d[bitn] == want) begin ok = 1; break; end
        end
    endtask

    task automatic wait_cnt(input int n);
        for (int i = 0; i < 20000; i++) begin
            if (sink_cnt >= n) break;
            @(negedge clk);
        end
    endtask

    // Count words that differ from the ring pattern starting at base word bw.
    function automatic int seq_err(input int bw, input int total);
        int e = 0;
        for (int k = 0; k < sink_cnt && k < 1024; k++)
            if (sink[k] != mem_init(bw + k % total)) e++;
        return e;
    endfunction

    task automatic stop_chan(input string tag);
        bit ok;
        wr(A_CMD, 32'd0);
        wait_stat(0, 1'b0, ok);
        chk(ok, tag, ok, 1);
    endtask

    initial begin
        logic [31:0] d;
        bit ok;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = mem_init(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset values
        rd(A_CMD, d);  chk(d == 0, "R12 CMD", d, 0);
        rd(A_STAT, d); chk(d == 0, "R12 STATUS", d, 0);
        rd(A_INT, d);  chk(d == 0, "R12 INT_STATUS", d, 0);
        rd(A_PROG, d); chk(d == 0, "R12 PROGRESS", d, 0);
        rd(A_CTRL, d); chk(d == 0, "R12 CTRL", d, 0);
        chk(!irq && !mem_valid && !per_tx_valid, "R12 outputs", {irq, mem_valid, per_tx_valid}, 0);

        // R1 R3 R5: memory to peripheral, 3 periods of 4 words, burst 2, looping
        wr(A_SRC, 32'h100);
        wr(A_TC, 32'd16);
        wr(A_CFG, (32'd2 << 28) | (32'd1 << 20) | 32'd1);
        wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8));
        sink_cnt = 0;
        wr(A_CMD, 32'd1);
        rd(A_STAT, d); chk(d[0] == 1'b1, "R1 STATUS active", d[0], 1);
        wait_cnt(30);
        wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8) | 32'd1);
        wait_stat(1, 1'b1, ok); chk(ok, "R6 paused status", ok, 1);
        n = sink_cnt;
        chk(n % 2 == 0, "R5 pause at burst boundary", n % 2, 0);
        chk(seq_err(32'h40, 12) == 0, "R3 ring sequence wraps to base", seq_err(32'h40, 12), 0);
        repeat (40) @(negedge clk);
        chk(sink_cnt == n && !mem_valid, "R6 no traffic while paused", sink_cnt, n);
        rd(A_INT, d); chk(d[0] == 1'b1, "R9 period flag set", d[0], 1);
        chk(irq == 1'b1, "R10 irq with flag and command", irq, 1);
        wr(A_CLR, 32'd1);
        rd(A_INT, d); chk(d[0] == 1'b0, "R9 flag cleared", d[0], 0);
        chk(irq == 1'b0, "R10 irq low after clear", irq, 0);
        wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8));
        wait_cnt(n + 6);
        chk(sink_cnt >= n + 6, "R6 resume continues", sink_cnt, n + 6);
        stop_chan("R7 halt after stop");
        rd(A_PROG, d);
        chk(d == ((sink_cnt / 4) % 256), "R11 progress counts periods", d, (sink_cnt / 4) % 256);
        rd(A_INT, d);
        chk(irq == 1'b0 && d[0] == 1'b1, "R10 irq gated by command", irq, 0);
        n = sink_cnt;
        repeat (30) @(negedge clk);
        chk(sink_cnt == n, "R7 no words after stop", sink_cnt, n);
        sink_cnt = 0;
        wr(A_CMD, 32'd1);
        wait_cnt(3);
        chk(sink[0] == mem_init(32'h40), "R7 restart at period 0", sink[0], mem_init(32'h40));
        stop_chan("R7 second stop");

        // R2: undefined direction code leaves the channel halted
        wr(A_CTRL, (32'd5 << 12) | (32'd2 << 8));
        wr(A_CMD, 32'd1);
        repeat (5) @(negedge clk);
        rd(A_STAT, d); chk(d[0] == 1'b0, "R2 bad direction ignored", d[0], 0);
        wr(A_CMD, 32'd0);

        // R2 R4: peripheral to memory, 2 periods of 3 words, single pass
        wr(A_TRG, 32'h400);
        wr(A_TC, 32'd12);
        wr(A_CFG, (32'd1 << 24) | (32'd3 << 20));
        wr(A_CTRL, 32'd2 << 12);
        n = src_cnt;
        wr(A_CMD, 32'd1);
        wait_stat(0, 1'b0, ok); chk(ok, "R4 single pass halts", ok, 1);
        for (int i = 0; i < 6; i++)
            chk(mem[256 + i] == 32'hA000 + n + i, "R2 R3 peripheral word stored",
                mem[256 + i], 32'hA000 + n + i);
        chk(mem[262] == mem_init(262), "R4 nothing past last period", mem[262], mem_init(262));
        rd(A_PROG, d); chk(d == 2, "R11 two periods done", d, 2);
        wr(A_CMD, 32'd0);

        // R8: flow control holds bursts until the request line rises
        wr(A_TC, 32'd8);
        wr(A_CFG, 32'd0 << 28);
        wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8) | 32'd2);
        per_req = 1'b0;
        sink_cnt = 0;
        wr(A_CMD, 32'd1);
        repeat (50) @(negedge clk);
        chk(sink_cnt == 0, "R8 no burst without request", sink_cnt, 0);
        per_req = 1'b1;
        wait_cnt(5);
        chk(sink_cnt >= 5, "R8 bursts after request", sink_cnt, 5);
        stop_chan("R8 stop");

        // R3 R5 R13: seeded random ring shapes under random backpressure
        for (int it = 0; it < 6; it++) begin
            int np, pw, bl, bw, tot, pos;
            np = 1 + $urandom % 8; pw = 1 + $urandom % 6; bl = 1 + $urandom % 16;
            bw = $urandom % 176; tot = np * pw;
            wr(A_SRC, bw * 4);
            wr(A_TC, pw * 4);
            wr(A_CFG, ((np - 1) << 28) | ((bl - 1) << 20));
            wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8));
            sink_cnt = 0;
            wr(A_CMD, 32'd1);
            wait_cnt(2 * tot + 3);
            wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8) | 32'd1);
            wait_stat(1, 1'b1, ok);
            pos = sink_cnt % pw;
            chk(ok && pos % bl == 0, "R5 burst granular pause", pos % bl, 0);
            chk(seq_err(bw, tot) == 0, "R3 R13 random ring data", seq_err(bw, tot), 0);
            wr(A_CTRL, (32'd4 << 12) | (32'd2 << 8));
            stop_chan("R7 random stop");
        end

        // R11: progress wraps with one-word periods
        rnd_rdy = 0;
        wr(A_SRC, 32'h0);
        wr(A_TC, 32'd4);
        wr(A_CFG, 32'd0);
        sink_cnt = 0;
        wr(A_CMD, 32'd1);
        wait_cnt(300);
        stop_chan("R11 stop");
        rd(A_PROG, d);
        chk(sink_cnt >= 256 && d == (sink_cnt % 256), "R11 progress wraps", d, sink_cnt % 256);

        summary();
    end
endmodule